// File: doc/BRIEF.md
# Lane-Parallel Stack Slot Allocator

This block hands out slots in a shared push buffer to a group of lanes that run in lockstep. In any cycle, any subset of the lanes, marked by a one-bit-per-lane active mask, may each push one item. Every active lane receives its own slot index in the same cycle. The slots are packed densely: the lowest-numbered active lane gets the current head, the next active lane gets head plus one, and so on. Inactive lanes take no slot, so the buffer has no gaps.

A lane's offset from the head is the number of active lanes with a lower index. It is found as a population count of the active mask, masked to the bit positions below that lane. The head is a register. It moves forward by the number of active lanes, wrapping at a parameterised buffer depth. The register is updated by the single active lane whose offset is zero. Slots handed out in a cycle use the head left by the previous cycle. A synchronous clear returns the head to zero.

Top module: `lane_slot_alloc`

## Requirements
- R1: When `head_clr` is high at a rising clock edge, `head` reads 0 after that edge. This holds even if `push` is high with a non-zero mask in the same cycle.
- R2: When `push` is high and bit i of `act_mask` (lane i) is set, the slot of lane i is (`head` + number of set mask bits below bit i) modulo DEPTH. The slot of lane i is bits [i*AW +: AW] of `slot_idx`.
- R3: When `push` is high and lane 0 is active, its slot equals the current `head`.
- R4: A lane whose mask bit is clear, or any lane while `push` is low, has bit i of `slot_vld` equal to 0 and a slot index of 0. An active lane while `push` is high has `slot_vld` bit i equal to 1.
- R5: After a rising edge with `push` high and `head_clr` low, `head` equals (previous `head` + number of set mask bits) modulo DEPTH. The new value is visible from that edge on, and it is used by the slots of the following cycle.
- R6: An all-zero mask, or `push` low, leaves `head` unchanged.
- R7: Both slot indices and `head` wrap modulo DEPTH (default 4096). This includes a single cycle whose slots cross the wrap point.
- R8: With all 32 lanes active, the slots are head, head+1, ..., head+31 (mod DEPTH) in lane order, and `head` advances by 32.
- R9: Among the active lanes, exactly one has offset zero. The valid slots of a cycle are distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| head_clr | input | 1 | Synchronous clear of the head register |
| push | input | 1 | Push strobe for this cycle |
| act_mask | input | 32 | One bit per lane; set means the lane pushes |
| slot_idx | output | 384 | Per-lane slot index, lane i at bits [i*12 +: 12] |
| slot_vld | output | 32 | Per-lane flag that the slot index is valid |
| head | output | 12 | Registered head, the next free slot |

## Verification
The bench goes after cycles whose slots cross from DEPTH-1 back to 0. A design that wraps only the head, and not the per-lane sums, would hand out slots past the buffer end there. It drives masks with only the top lane, only lane 0, or every lane set, because an off-by-one in the below-me mask moves each slot by one or counts the lane itself. It also drives an all-zero mask with the strobe high and a clear together with a push. A wrong design would advance the head on an empty push or let the push win over the clear. Random sparse masks and single-bit masks check that inactive lanes read zero and invalid and never disturb the numbering of the lanes above them.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  // Widest lane group the counting functions accept.
  localparam int unsigned MAX_LANES = 64;

  // Number of set bits in a lane vector.
  function automatic int unsigned count_ones(input logic [MAX_LANES-1:0] v);
    int unsigned n;
    n = 0;
    for (int k = 0; k < MAX_LANES; k++) begin
      if (v[k]) n++;
    end
    return n;
  endfunction

  // (a + b) mod depth, assuming a < depth and b <= depth.
  function automatic int unsigned mod_add(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned depth);
    int unsigned s;
    s = a + b;
    if (s >= depth) s = s - depth;
    return s;
  endfunction
endpackage

// File: rtl/lsa_prefix_count.sv
module lsa_prefix_count
  import lsa_pkg::*;
#(
  parameter int unsigned LANES = 32,
  parameter int unsigned CW    = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]    mask,
  output logic [LANES*CW-1:0] offs,
  output logic [CW-1:0]       total,
  output logic [LANES-1:0]    lead
);
  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic [LANES-1:0] below;
    logic [LANES-1:0] lower_act;

    // Bits 0 .. gi-1 set: the lanes under this one.
    always_comb begin
      below = '0;
      for (int k = 0; k < gi; k++) below[k] = 1'b1;
    end

    assign lower_act = mask & below;
    assign offs[gi*CW +: CW] = CW'(count_ones(MAX_LANES'(lower_act)));
    // Leader: active with no active lane below it.
    assign lead[gi] = mask[gi] & ~(|lower_act);
  end

  assign total = CW'(count_ones(MAX_LANES'(mask)));
endmodule

// File: rtl/lsa_head_reg.sv
module lsa_head_reg
  import lsa_pkg::*;
#(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned CW    = 6
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  input  logic [CW-1:0] step,
  output logic [AW-1:0] head
);
  always_ff @(posedge clk) begin
    if (clr)      head <= '0;
    else if (adv) head <= AW'(mod_add(32'(head), 32'(step), DEPTH));
  end

  // R1: the clear wins over any push in the same cycle
  p_clear_zero_r1: assert property (@(posedge clk) clr |=> (head == '0));

  // R6: no advance request, no movement
  p_hold_r6: assert property (@(posedge clk) disable iff (clr)
    !adv |=> $stable(head));
endmodule

// File: rtl/lsa_slot_gen.sv
module lsa_slot_gen
  import lsa_pkg::*;
#(
  parameter int unsigned LANES = 32,
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(LANES + 1)
) (
  input  logic [AW-1:0]       head,
  input  logic [LANES*CW-1:0] offs,
  input  logic [LANES-1:0]    mask,
  input  logic                push,
  output logic [LANES*AW-1:0] slot_idx,
  output logic [LANES-1:0]    slot_vld
);
  for (genvar gi = 0; gi < LANES; gi++) begin : g_slot
    logic [AW-1:0] addr;
    assign addr = AW'(mod_add(32'(head), 32'(offs[gi*CW +: CW]), DEPTH));
    assign slot_vld[gi] = push & mask[gi];
    assign slot_idx[gi*AW +: AW] = slot_vld[gi] ? addr : '0;
  end
endmodule

// File: rtl/lane_slot_alloc.sv
module lane_slot_alloc
  import lsa_pkg::*;
#(
  parameter int unsigned LANES = 32,
  parameter int unsigned DEPTH = 4096,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                head_clr,
  input  logic                push,
  input  logic [LANES-1:0]    act_mask,
  output logic [LANES*AW-1:0] slot_idx,
  output logic [LANES-1:0]    slot_vld,
  output logic [AW-1:0]       head
);
  // Named internal events for the assertions.
  logic [LANES*CW-1:0] offs;
  logic [CW-1:0]       total;
  logic [LANES-1:0]    lead;
  logic                head_adv;

  lsa_prefix_count #(.LANES(LANES), .CW(CW)) u_prefix (
    .mask  (act_mask),
    .offs  (offs),
    .total (total),
    .lead  (lead)
  );

  // Only the lane at offset zero moves the head.
  assign head_adv = push & (|lead);

  lsa_head_reg #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_head (
    .clk  (clk),
    .clr  (head_clr),
    .adv  (head_adv),
    .step (total),
    .head (head)
  );

  lsa_slot_gen #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_slots (
    .head     (head),
    .offs     (offs),
    .mask     (act_mask),
    .push     (push),
    .slot_idx (slot_idx),
    .slot_vld (slot_vld)
  );

  // Checker side: slot one past the highest valid lane.
  logic [AW-1:0] past_last;
  always_comb begin
    past_last = head;
    for (int k = 0; k < LANES; k++) begin
      if (slot_vld[k])
        past_last = AW'(mod_add(32'(slot_idx[k*AW +: AW]), 1, DEPTH));
    end
  end

  // R5: the new head starts right after the last slot handed out
  p_head_follows_r5: assert property (@(posedge clk) disable iff (head_clr)
    (push && (|act_mask)) |=> (head == $past(past_last)));

  // R6: empty mask or no strobe keeps the head
  p_idle_r6: assert property (@(posedge clk) disable iff (head_clr)
    (!push || act_mask == '0) |=> $stable(head));

  // R3: lane 0 takes the head itself
  p_lane0_r3: assert property (@(posedge clk) disable iff (head_clr)
    (push && act_mask[0]) |-> (slot_idx[AW-1:0] == head));

  // R9: exactly one leader whenever some lane is active
  p_one_leader_r9: assert property (@(posedge clk) disable iff (head_clr)
    (act_mask != '0) |-> $onehot(lead));

  // R8: a full group ends at head + LANES - 1
  p_full_span_r8: assert property (@(posedge clk) disable iff (head_clr)
    (push && act_mask == '1) |->
      (slot_idx[(LANES-1)*AW +: AW] == AW'(mod_add(32'(head), LANES - 1, DEPTH))));
endmodule

// File: tb/lane_slot_alloc_tb.sv
module lane_slot_alloc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;
  localparam int DEPTH = 4096;
  localparam int AW    = 12;

  logic                clk = 1'b0;
  logic                head_clr = 1'b1;
  logic                push = 1'b0;
  logic [LANES-1:0]    act_mask = '0;
  logic [LANES*AW-1:0] slot_idx;
  logic [LANES-1:0]    slot_vld;
  logic [AW-1:0]       head;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  int unsigned mhead    = 0;
  string       head_tag = "R1";
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_slot_alloc u_dut (
    .clk      (clk),
    .head_clr (head_clr),
    .push     (push),
    .act_mask (act_mask),
    .slot_idx (slot_idx),
    .slot_vld (slot_vld),
    .head     (head)
  );

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic string lane_tag(input int lane, input bit full, input bit wrapped);
    if (wrapped) return "R7";
    if (full) return "R8";
    if (lane == 0) return "R3";
    return "R2";
  endfunction

  // One cycle: drive, check outputs mid-cycle, then advance the model.
  task automatic step(input logic [LANES-1:0] m, input logic p, input logic c);
    int unsigned run;
    @(negedge clk);
    act_mask = m; push = p; head_clr = c;
    #1;
    check(head_tag, head, mhead);
    run = 0;
    if (!c) begin
      for (int i = 0; i < LANES; i++) begin
        if (p && m[i]) begin
          int unsigned e;
          e = (mhead + run) % DEPTH;
          check("R4", slot_vld[i], 1);
          check(lane_tag(i, m == '1, e < mhead), slot_idx[i*AW +: AW], e);
          run++;
        end else begin
          check("R4", slot_vld[i], 0);
          check("R4", slot_idx[i*AW +: AW], 0);
        end
      end
    end else begin
      for (int i = 0; i < LANES; i++) if (p && m[i]) run++;
    end
    @(posedge clk);
    if (c) begin
      mhead = 0; head_tag = "R1";
    end else if (p && run != 0) begin
      mhead = (mhead + run) % DEPTH;
      head_tag = (run == LANES) ? "R8" : "R5";
    end else begin
      head_tag = "R6";
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    step('0, 1'b0, 1'b1);
    step('0, 1'b0, 1'b1);
    // Directed corners
    step(32'h0000_0001, 1'b1, 1'b0);        // R3 lane 0 only
    step(32'h0000_0000, 1'b1, 1'b0);        // R6 empty mask with strobe
    step(32'hFFFF_FFFF, 1'b0, 1'b0);        // R4/R6 strobe low
    step(32'h8000_0000, 1'b1, 1'b0);        // R2 top lane only
    step(32'h8000_0001, 1'b1, 1'b0);        // R2 sparse ends
    step(32'hFFFF_FFFF, 1'b1, 1'b1);        // R1 clear beats push
    step(32'h0000_0001, 1'b1, 1'b0);        // head 1
    for (int k = 0; k < 127; k++) step(32'hFFFF_FFFF, 1'b1, 1'b0); // R8
    step(32'hFFFF_FFFF, 1'b1, 1'b0);        // R7 slots cross wrap
    step(32'hAAAA_5555, 1'b1, 1'b0);
    step('0, 1'b0, 1'b0);
    // Constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [LANES-1:0] m;
      int unsigned sel;
      sel = $urandom % 4;
      case (sel)
        0: m = $urandom;
        1: m = $urandom & $urandom & $urandom;
        2: m = 32'h1 << ($urandom % LANES);
        default: m = ($urandom % 3 == 0) ? '0 : '1;
      endcase
      step(m, ($urandom % 8) != 0, ($urandom % 250) == 0);
    end
    step('0, 1'b0, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule